// File: doc/BRIEF.md
# MMU Register Decoder

This block sits behind the load/store unit. It serves loads and stores that name an alternate address space. Each access carries a 4-bit space code and an 11-bit byte offset. From these the block picks one register out of a small bank: two context registers, a partition identifier, one tag-access register per TLB (instruction and data), eight scratchpad registers and four interrupt-queue pointers. Every access gets one response in the next clock, with read data and a 2-bit fault code.

The block also checks whether an access is legal for the current privilege level. A user-mode or privileged-mode access can raise a data-access fault or a privileged-action fault. A combination of space code and offset that the block does not decode gets an error response. It never stalls.

A store to one of the four TLB data spaces is not kept in the bank. The block turns it into a one-cycle insert command for the TLB array, which lives outside the block. The command carries:
- the virtual page number and context, taken from the matching tag-access register;
- the partition identifier;
- the real and format flags and the entry index, taken from offset bits;
- the store data as the page-table entry.

Top module: `mmu_reg_decoder`

## Requirements
- R1: Every cycle with `reqValid` high is answered by `rspValid` high exactly one clock later. A legal write has updated its register by the time that response is seen.
- R2: In space code 0, offset 0x8 is the primary context and offset 0x10 is the secondary context. Each keeps only the low 13 bits of the written data, and a read returns those bits zero-extended.
- R3: In space code 1, offset 0x30 is the data tag-access register (full 64 bits) and offset 0x80 is the partition identifier (low 8 bits kept). In space code 2, offset 0x30 is a separate instruction tag-access register.
- R4: The fault code reads 0 for none, 1 for data-access fault, 2 for privileged-action fault and 3 for undecoded. Code 3 is returned for three cases: any offset not listed in spaces 0 to 2, any space code above 9, and a read of spaces 6 to 9.
- R5: Space code 3 is the scratchpad, indexed by offset bits 5:3. An offset above 0x38 gives fault 1. An offset from 0x20 to 0x2F without hyper-privilege also gives fault 1.
- R6: Space code 4 is the interrupt queue. The index is (offset >> 4) − 0x3C, and only offsets 0x3C0 to 0x3F8 are legal.
  - An access with neither privilege nor hyper-privilege gives fault 2.
  - Otherwise, an offset outside the range gives fault 1.
  - So does a privileged access with offset bits 3:0 nonzero.
  - A hyper-privileged, non-privileged access ignores the low nibble.
  - Stored data keeps only bits 13:6.
- R7: Space code 5 is the error space. Without hyper-privilege, a privileged access gives fault 1 and a user access gives fault 2. With hyper-privilege, a read returns zero and a write is accepted with no effect.
- R8: An access that faults changes no register and returns zero data.
- R9: A write to space 9 (data TLB) or space 7 (instruction TLB) with an explicit entry index issues one insert command. `insValid` is high in the same cycle as `rspValid`, `insEntry` is offset bits 8:3 and `insAuto` is 0.
- R10: A write to space 8 (data TLB) or space 6 (instruction TLB) lets the TLB pick the victim. It issues an insert with `insAuto` 1 and `insEntry` 0.
- R11: Every insert carries the following fields:
  - `insReal` is offset bit 9 and `insFormat` is offset bit 10;
  - `insVpn` is tag-access bits 63:13 and `insCtx` is tag-access bits 12:0, from the instruction tag for spaces 6 and 7 (`insInstr` 1) and from the data tag for spaces 8 and 9 (`insInstr` 0);
  - `insPart` is the partition identifier and `insPte` is the write data.
- R12: After reset, every register reads zero and neither `rspValid` nor `insValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqSpace | input | 4 | Address-space code |
| reqOffset | input | OFF_W | Byte offset within the space |
| reqData | input | DATA_W | Store data |
| privMode | input | 1 | Requester is privileged |
| hyperMode | input | 1 | Requester is hyper-privileged |
| rspValid | output | 1 | Response for last cycle's request |
| rspFault | output | 2 | Fault code (R4) |
| rspData | output | DATA_W | Load data, zero on fault |
| insValid | output | 1 | TLB insert command |
| insInstr | output | 1 | 1 = instruction TLB, 0 = data TLB |
| insAuto | output | 1 | TLB chooses the victim entry |
| insEntry | output | 6 | Explicit entry index |
| insReal | output | 1 | Real-address mapping flag |
| insFormat | output | 1 | Page-table-entry format select |
| insVpn | output | DATA_W-CTX_W | Virtual page number |
| insCtx | output | CTX_W | Context number |
| insPart | output | PART_W | Partition identifier |
| insPte | output | DATA_W | Page-table-entry data |

## Verification
The bench goes after the legality boundaries: scratch offsets 0x20, 0x28, 0x38 and 0x40; queue offsets 0x3B0, 0x3C8 and 0x400; and the user, privileged and hyper-privileged cases. A decoder with an off-by-one range compare or a swapped fault priority would return the wrong fault code at exactly these points. Faulting and undecoded writes are each followed by a read of the register they could have hit, which exposes a write strobe that is not gated by the fault. Insert commands are checked field by field from both tag registers. A design that took the wrong tag, swapped the real and format bits, or kept an entry index for victim-chosen inserts would miscompare.

// File: rtl/mmureg_pkg.sv
package mmureg_pkg;

  localparam int SCR_N = 8;
  localparam int QUE_N = 4;
  localparam int IDX_W = 3;

  typedef enum logic [3:0] {
    SP_CTX  = 4'd0,
    SP_DMMU = 4'd1,
    SP_IMMU = 4'd2,
    SP_SCR  = 4'd3,
    SP_QUE  = 4'd4,
    SP_ERR  = 4'd5,
    SP_IDIN = 4'd6,
    SP_IACC = 4'd7,
    SP_DDIN = 4'd8,
    SP_DACC = 4'd9
  } space_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_DATA  = 2'd1,
    FLT_PRIV  = 2'd2,
    FLT_UNDEF = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    RD_ZERO, RD_PRI, RD_SEC, RD_PART, RD_DTAG, RD_ITAG, RD_SCR, RD_QUE
  } rdsel_e;

  typedef struct packed {
    logic             wrPri;
    logic             wrSec;
    logic             wrPart;
    logic             wrDTag;
    logic             wrITag;
    logic             wrScr;
    logic             wrQue;
    logic             ins;
    logic             insInstr;
    logic             insAuto;
    rdsel_e           rdSel;
    logic [IDX_W-1:0] idx;
  } strobe_t;

endpackage

// File: rtl/mmureg_ctrl.sv
module mmureg_ctrl
  import mmureg_pkg::*;
#(
  parameter int OFF_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [3:0]       reqSpace,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic             privMode,
  input  logic             hyperMode,
  output strobe_t          strb,
  output logic             rspValid,
  output logic [1:0]       rspFault
);

  strobe_t rawStrb;
  fault_e  fault;

  always_comb begin
    rawStrb = '0;
    fault   = FLT_NONE;
    case (space_e'(reqSpace))
      SP_CTX: begin
        if (reqOffset == OFF_W'('h8)) begin
          rawStrb.wrPri = reqWrite;  rawStrb.rdSel = RD_PRI;
        end else if (reqOffset == OFF_W'('h10)) begin
          rawStrb.wrSec = reqWrite;  rawStrb.rdSel = RD_SEC;
        end else fault = FLT_UNDEF;
      end
      SP_DMMU: begin
        if (reqOffset == OFF_W'('h30)) begin
          rawStrb.wrDTag = reqWrite; rawStrb.rdSel = RD_DTAG;
        end else if (reqOffset == OFF_W'('h80)) begin
          rawStrb.wrPart = reqWrite; rawStrb.rdSel = RD_PART;
        end else fault = FLT_UNDEF;
      end
      SP_IMMU: begin
        if (reqOffset == OFF_W'('h30)) begin
          rawStrb.wrITag = reqWrite; rawStrb.rdSel = RD_ITAG;
        end else fault = FLT_UNDEF;
      end
      SP_SCR: begin
        if (reqOffset > OFF_W'('h38) ||
            (reqOffset >= OFF_W'('h20) && reqOffset < OFF_W'('h30) && !hyperMode))
          fault = FLT_DATA;
        else begin
          rawStrb.wrScr = reqWrite;
          rawStrb.rdSel = RD_SCR;
          rawStrb.idx   = reqOffset[5:3];
        end
      end
      SP_QUE: begin
        if (!privMode && !hyperMode) fault = FLT_PRIV;
        else if ((privMode && reqOffset[3:0] != 4'h0) ||
                 reqOffset > OFF_W'('h3F8) || reqOffset < OFF_W'('h3C0))
          fault = FLT_DATA;
        else begin
          rawStrb.wrQue = reqWrite;
          rawStrb.rdSel = RD_QUE;
          rawStrb.idx   = IDX_W'((reqOffset >> 4) - OFF_W'('h3C));
        end
      end
      SP_ERR: begin
        if (!hyperMode) fault = privMode ? FLT_DATA : FLT_PRIV;
        else rawStrb.rdSel = RD_ZERO;
      end
      SP_IDIN, SP_IACC, SP_DDIN, SP_DACC: begin
        if (!reqWrite) fault = FLT_UNDEF;
        else begin
          rawStrb.ins      = 1'b1;
          rawStrb.insInstr = (reqSpace == 4'(SP_IDIN)) || (reqSpace == 4'(SP_IACC));
          rawStrb.insAuto  = (reqSpace == 4'(SP_IDIN)) || (reqSpace == 4'(SP_DDIN));
        end
      end
      default: fault = FLT_UNDEF;
    endcase
  end

  // Faulting or idle cycles drive no strobe; a faulting read selects zero.
  assign strb = (reqValid && fault == FLT_NONE) ? rawStrb : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= 2'(FLT_NONE);
    end else begin
      rspValid <= reqValid;
      rspFault <= reqValid ? 2'(fault) : 2'(FLT_NONE);
    end
  end

  assert_one_cycle_rsp_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_undef_space_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSpace > 4'd9) |=> rspFault == 2'(FLT_UNDEF));

  assert_user_queue_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSpace == 4'(SP_QUE) && !privMode && !hyperMode)
      |=> rspFault == 2'(FLT_PRIV));

  assert_err_needs_hyper_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSpace == 4'(SP_ERR) && !hyperMode)
      |=> (rspFault == 2'(FLT_DATA) || rspFault == 2'(FLT_PRIV)));

endmodule

// File: rtl/mmureg_dp.sv
module mmureg_dp
  import mmureg_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CTX_W  = 13,
  parameter int PART_W = 8,
  parameter int OFF_W  = 11
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strb,
  input  logic [OFF_W-1:0]          reqOffset,
  input  logic [DATA_W-1:0]         reqData,
  output logic [DATA_W-1:0]         rspData,
  output logic                      insValid,
  output logic                      insInstr,
  output logic                      insAuto,
  output logic [5:0]                insEntry,
  output logic                      insReal,
  output logic                      insFormat,
  output logic [DATA_W-CTX_W-1:0]   insVpn,
  output logic [CTX_W-1:0]          insCtx,
  output logic [PART_W-1:0]         insPart,
  output logic [DATA_W-1:0]         insPte
);

  localparam logic [DATA_W-1:0] QUE_MASK = {{(DATA_W-14){1'b0}}, 8'hFF, 6'b0};

  logic [CTX_W-1:0]  priCtx, secCtx;
  logic [PART_W-1:0] partId;
  logic [DATA_W-1:0] dTag, iTag;
  logic [DATA_W-1:0] scrRd [SCR_N];
  logic [DATA_W-1:0] queRd [QUE_N];
  logic [DATA_W-1:0] rdMux, insTag;
  logic              unusedLow;

  assign unusedLow = ^reqOffset[2:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      priCtx <= '0; secCtx <= '0; partId <= '0; dTag <= '0; iTag <= '0;
    end else begin
      if (strb.wrPri)  priCtx <= reqData[CTX_W-1:0];
      if (strb.wrSec)  secCtx <= reqData[CTX_W-1:0];
      if (strb.wrPart) partId <= reqData[PART_W-1:0];
      if (strb.wrDTag) dTag   <= reqData;
      if (strb.wrITag) iTag   <= reqData;
    end
  end

  for (genvar g = 0; g < SCR_N; g++) begin : gScr
    logic [DATA_W-1:0] scrQ;
    always_ff @(posedge clk) begin
      if (!rstN) scrQ <= '0;
      else if (strb.wrScr && strb.idx == IDX_W'(g)) scrQ <= reqData;
    end
    assign scrRd[g] = scrQ;
  end

  for (genvar g = 0; g < QUE_N; g++) begin : gQue
    logic [DATA_W-1:0] queQ;
    always_ff @(posedge clk) begin
      if (!rstN) queQ <= '0;
      else if (strb.wrQue && strb.idx == IDX_W'(g)) queQ <= reqData & QUE_MASK;
    end
    assign queRd[g] = queQ;
  end

  always_comb begin
    case (strb.rdSel)
      RD_PRI:  rdMux = DATA_W'(priCtx);
      RD_SEC:  rdMux = DATA_W'(secCtx);
      RD_PART: rdMux = DATA_W'(partId);
      RD_DTAG: rdMux = dTag;
      RD_ITAG: rdMux = iTag;
      RD_SCR:  rdMux = scrRd[strb.idx];
      RD_QUE:  rdMux = queRd[strb.idx[1:0]];
      default: rdMux = '0;
    endcase
  end

  assign insTag = strb.insInstr ? iTag : dTag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspData <= '0; insValid <= 1'b0; insInstr <= 1'b0; insAuto <= 1'b0;
      insEntry <= '0; insReal <= 1'b0; insFormat <= 1'b0; insVpn <= '0;
      insCtx <= '0; insPart <= '0; insPte <= '0;
    end else begin
      rspData  <= rdMux;
      insValid <= strb.ins;
      if (strb.ins) begin
        insInstr  <= strb.insInstr;
        insAuto   <= strb.insAuto;
        insEntry  <= strb.insAuto ? 6'd0 : reqOffset[8:3];
        insReal   <= reqOffset[9];
        insFormat <= reqOffset[10];
        insVpn    <= insTag[DATA_W-1:CTX_W];
        insCtx    <= insTag[CTX_W-1:0];
        insPart   <= partId;
        insPte    <= reqData;
      end
    end
  end

  assert_ctx_low_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.wrPri) |-> priCtx == $past(reqData[CTX_W-1:0]));

  assert_ins_dtag_ctx_R11: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && !insInstr) |-> insCtx == $past(dTag[CTX_W-1:0]));

  assert_ins_auto_entry_R10: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && insAuto) |-> insEntry == 6'd0);

endmodule

// File: rtl/mmu_reg_decoder.sv
module mmu_reg_decoder
  import mmureg_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CTX_W  = 13,
  parameter int PART_W = 8,
  parameter int OFF_W  = 11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [3:0]              reqSpace,
  input  logic [OFF_W-1:0]        reqOffset,
  input  logic [DATA_W-1:0]       reqData,
  input  logic                    privMode,
  input  logic                    hyperMode,
  output logic                    rspValid,
  output logic [1:0]              rspFault,
  output logic [DATA_W-1:0]       rspData,
  output logic                    insValid,
  output logic                    insInstr,
  output logic                    insAuto,
  output logic [5:0]              insEntry,
  output logic                    insReal,
  output logic                    insFormat,
  output logic [DATA_W-CTX_W-1:0] insVpn,
  output logic [CTX_W-1:0]        insCtx,
  output logic [PART_W-1:0]       insPart,
  output logic [DATA_W-1:0]       insPte
);

  strobe_t strb;

  mmureg_ctrl #(.OFF_W(OFF_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSpace(reqSpace), .reqOffset(reqOffset), .privMode(privMode),
    .hyperMode(hyperMode), .strb(strb), .rspValid(rspValid), .rspFault(rspFault)
  );

  mmureg_dp #(.DATA_W(DATA_W), .CTX_W(CTX_W), .PART_W(PART_W), .OFF_W(OFF_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqOffset(reqOffset), .reqData(reqData),
    .rspData(rspData), .insValid(insValid), .insInstr(insInstr), .insAuto(insAuto),
    .insEntry(insEntry), .insReal(insReal), .insFormat(insFormat), .insVpn(insVpn),
    .insCtx(insCtx), .insPart(insPart), .insPte(insPte)
  );

  assert_fault_zero_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 2'(FLT_NONE)) |-> rspData == '0);

  assert_ins_with_rsp_R9: assert property (@(posedge clk) disable iff (!rstN)
    insValid |-> (rspValid && rspFault == 2'(FLT_NONE)));

endmodule

// File: tb/sim_mmu_reg_decoder.sv
module sim_mmu_reg_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, privMode = 1'b0, hyperMode = 1'b0;
  logic [3:0]  reqSpace = '0;
  logic [10:0] reqOffset = '0;
  logic [63:0] reqData = '0;
  logic        rspValid, insValid, insInstr, insAuto, insReal, insFormat;
  logic [1:0]  rspFault;
  logic [63:0] rspData, insPte;
  logic [5:0]  insEntry;
  logic [50:0] insVpn;
  logic [12:0] insCtx;
  logic [7:0]  insPart;

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct {
    logic [1:0]  fault;
    logic [63:0] data;
    bit          ins, instr, isAuto, isReal, fmt;
    logic [5:0]  entry;
    logic [50:0] vpn;
    logic [12:0] ctx;
    logic [7:0]  part;
    logic [63:0] pte;
    string       tag;
  } exp_t;

  exp_t expQ[$];

  always #4 clk = ~clk;

  mmu_reg_decoder u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSpace(reqSpace), .reqOffset(reqOffset), .reqData(reqData),
    .privMode(privMode), .hyperMode(hyperMode), .rspValid(rspValid),
    .rspFault(rspFault), .rspData(rspData), .insValid(insValid),
    .insInstr(insInstr), .insAuto(insAuto), .insEntry(insEntry),
    .insReal(insReal), .insFormat(insFormat), .insVpn(insVpn),
    .insCtx(insCtx), .insPart(insPart), .insPte(insPte)
  );

  task automatic drive(input bit wr, input logic [3:0] sp, input logic [10:0] off,
                       input logic [63:0] d, input bit pv, input bit hv, input exp_t e);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSpace = sp; reqOffset = off;
    reqData = d; privMode = pv; hyperMode = hv;
    @(posedge clk); #1;
    expQ.push_back(e);
    reqValid = 1'b0;
  endtask

  task automatic access(input bit wr, input logic [3:0] sp, input logic [10:0] off,
                        input logic [63:0] d, input bit pv, input bit hv,
                        input logic [1:0] f, input logic [63:0] ed, input string tag);
    exp_t e;
    e = '{fault: f, data: ed, ins: 0, instr: 0, isAuto: 0, isReal: 0, fmt: 0,
          entry: '0, vpn: '0, ctx: '0, part: '0, pte: '0, tag: tag};
    drive(wr, sp, off, d, pv, hv, e);
  endtask

  task automatic tlbWrite(input logic [3:0] sp, input logic [10:0] off, input logic [63:0] d,
                          input logic [63:0] tagWord, input logic [7:0] part, input string tag);
    exp_t e;
    bit instr, auto_;
    instr = (sp == 4'd6) || (sp == 4'd7);
    auto_ = (sp == 4'd6) || (sp == 4'd8);
    e = '{fault: 2'd0, data: 64'd0, ins: 1, instr: instr, isAuto: auto_,
          isReal: off[9], fmt: off[10], entry: auto_ ? 6'd0 : off[8:3],
          vpn: tagWord[63:13], ctx: tagWord[12:0], part: part, pte: d, tag: tag};
    drive(1'b1, sp, off, d, 1'b1, 1'b0, e);
  endtask

  // Monitor: scoreboard pop-and-compare, away from the active edge.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (expQ.size() == 0) begin
        if (rspValid || insValid) begin
          checks++; errors++;
          $display("FAIL R1 unexpected response rspValid=%0b insValid=%0b expected 0 0",
                   rspValid, insValid);
        end
      end else begin
        exp_t e;
        bit bad;
        e = expQ.pop_front();
        checks++;
        bad = !rspValid || rspFault !== e.fault || rspData !== e.data || insValid !== e.ins;
        if (e.ins)
          bad = bad || insInstr !== e.instr || insAuto !== e.isAuto || insReal !== e.isReal ||
                insFormat !== e.fmt || insEntry !== e.entry || insVpn !== e.vpn ||
                insCtx !== e.ctx || insPart !== e.part || insPte !== e.pte;
        if (bad) begin
          errors++;
          $display("FAIL %s: got v=%0b f=%0d d=%h ins=%0b i=%0b a=%0b r=%0b fm=%0b e=%0d vpn=%h c=%h p=%h pte=%h | exp f=%0d d=%h ins=%0b i=%0b a=%0b r=%0b fm=%0b e=%0d vpn=%h c=%h p=%h pte=%h",
                   e.tag, rspValid, rspFault, rspData, insValid, insInstr, insAuto, insReal,
                   insFormat, insEntry, insVpn, insCtx, insPart, insPte,
                   e.fault, e.data, e.ins, e.instr, e.isAuto, e.isReal, e.fmt, e.entry,
                   e.vpn, e.ctx, e.part, e.pte);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired, run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [63:0] D_TAG = 64'hDEAD_BEEF_0000_2ABC;
  localparam logic [63:0] I_TAG = 64'h1234_5678_9ABC_C005;

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rspValid !== 1'b0 || insValid !== 1'b0) begin
      errors++;
      $display("FAIL R12 outputs in reset rspValid=%0b insValid=%0b expected 0 0", rspValid, insValid);
    end
    rstN = 1'b1;

    // R12: registers read zero after reset
    access(0, 4'd0, 11'h8,  0, 1, 1, 2'd0, 64'd0, "R12 primary after reset");
    access(0, 4'd1, 11'h80, 0, 1, 1, 2'd0, 64'd0, "R12 partition after reset");
    access(0, 4'd3, 11'h0,  0, 1, 1, 2'd0, 64'd0, "R12 scratch after reset");
    access(0, 4'd4, 11'h3C0,0, 1, 1, 2'd0, 64'd0, "R12 queue after reset");

    // R2 context registers, R1 back-to-back write then read
    access(1, 4'd0, 11'h8,  64'hABCD_5234, 1, 0, 2'd0, 64'd0, "R2 write primary");
    access(0, 4'd0, 11'h8,  0, 1, 0, 2'd0, 64'h1234, "R1 R2 read primary");
    access(1, 4'd0, 11'h10, 64'h777, 1, 0, 2'd0, 64'd0, "R2 write secondary");
    access(0, 4'd0, 11'h10, 0, 1, 0, 2'd0, 64'h777, "R2 read secondary");

    // R3 tag access and partition
    access(1, 4'd1, 11'h30, D_TAG, 1, 0, 2'd0, 64'd0, "R3 write data tag");
    access(1, 4'd2, 11'h30, I_TAG, 1, 0, 2'd0, 64'd0, "R3 write instr tag");
    access(1, 4'd1, 11'h80, 64'h1A5, 1, 0, 2'd0, 64'd0, "R3 write partition");
    access(0, 4'd1, 11'h30, 0, 1, 0, 2'd0, D_TAG, "R3 read data tag");
    access(0, 4'd2, 11'h30, 0, 1, 0, 2'd0, I_TAG, "R3 read instr tag");
    access(0, 4'd1, 11'h80, 0, 1, 0, 2'd0, 64'hA5, "R3 read partition");

    // R4 undecoded combinations, R8 no state change
    access(1, 4'd0, 11'h18, 64'hFFFF, 1, 1, 2'd3, 64'd0, "R4 undefined ctx offset write");
    access(0, 4'd2, 11'h80, 0, 1, 1, 2'd3, 64'd0, "R4 undefined instr mmu offset");
    access(1, 4'd15, 11'h8, 64'h55, 1, 1, 2'd3, 64'd0, "R4 unknown space code");
    access(0, 4'd8, 11'h0,  0, 1, 1, 2'd3, 64'd0, "R4 read of tlb data space");
    access(0, 4'd0, 11'h8,  0, 1, 0, 2'd0, 64'h1234, "R8 primary unchanged");
    access(0, 4'd0, 11'h10, 0, 1, 0, 2'd0, 64'h777, "R8 secondary unchanged");

    // R5 scratchpad
    access(1, 4'd3, 11'h28, 64'h55, 0, 1, 2'd0, 64'd0, "R5 hyper write 0x28");
    access(0, 4'd3, 11'h28, 0, 0, 1, 2'd0, 64'h55, "R5 hyper read 0x28");
    access(0, 4'd3, 11'h28, 0, 1, 0, 2'd1, 64'd0, "R5 priv read 0x28 faults");
    access(1, 4'd3, 11'h20, 64'h99, 1, 0, 2'd1, 64'd0, "R5 priv write 0x20 faults");
    access(0, 4'd3, 11'h20, 0, 1, 1, 2'd0, 64'd0, "R8 scratch 0x20 unchanged");
    access(1, 4'd3, 11'h38, 64'h77, 1, 0, 2'd0, 64'd0, "R5 priv write 0x38");
    access(0, 4'd3, 11'h38, 0, 0, 0, 2'd0, 64'h77, "R5 user read 0x38");
    access(0, 4'd3, 11'h40, 0, 1, 1, 2'd1, 64'd0, "R5 offset above 0x38 faults");
    access(0, 4'd3, 11'h10, 0, 1, 0, 2'd0, 64'd0, "R5 other index untouched");

    // R6 interrupt queue
    access(1, 4'd4, 11'h3C0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 2'd0, 64'd0, "R6 write queue 0");
    access(0, 4'd4, 11'h3C0, 0, 1, 0, 2'd0, 64'h3FC0, "R6 queue data masked to 13:6");
    access(1, 4'd4, 11'h3F0, 64'h1240, 1, 0, 2'd0, 64'd0, "R6 write queue 3");
    access(0, 4'd4, 11'h3F0, 0, 1, 0, 2'd0, 64'h1240, "R6 read queue 3");
    access(0, 4'd4, 11'h3C0, 0, 0, 0, 2'd2, 64'd0, "R6 user access privileged-action");
    access(0, 4'd4, 11'h3C8, 0, 1, 0, 2'd1, 64'd0, "R6 priv low nibble faults");
    access(0, 4'd4, 11'h3C8, 0, 0, 1, 2'd0, 64'h3FC0, "R6 hyper low nibble accepted");
    access(0, 4'd4, 11'h3B0, 0, 1, 0, 2'd1, 64'd0, "R6 below range faults");
    access(0, 4'd4, 11'h400, 0, 1, 0, 2'd1, 64'd0, "R6 above range faults");

    // R7 error space
    access(0, 4'd5, 11'h0, 0, 1, 0, 2'd1, 64'd0, "R7 priv no hyper data fault");
    access(1, 4'd5, 11'h0, 64'h1, 0, 0, 2'd2, 64'd0, "R7 user privileged-action");
    access(1, 4'd5, 11'h8, 64'hFF, 1, 1, 2'd0, 64'd0, "R7 hyper write ignored");
    access(0, 4'd5, 11'h8, 0, 1, 1, 2'd0, 64'd0, "R7 hyper read zero");

    // R9 R10 R11 TLB inserts
    tlbWrite(4'd9, 11'h528, 64'hCAFE, D_TAG, 8'hA5, "R9 R11 data tlb explicit entry");
    tlbWrite(4'd6, 11'h200, 64'h8000_0000_0000_0001, I_TAG, 8'hA5, "R10 R11 instr tlb auto");
    tlbWrite(4'd8, 11'h600, 64'h1357, D_TAG, 8'hA5, "R10 R11 data tlb auto");
    tlbWrite(4'd7, 11'h018, 64'h2468, I_TAG, 8'hA5, "R9 R11 instr tlb explicit entry");

    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R1 responses missing: %0d outstanding, expected 0", expQ.size());
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule